// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses through a small, fully associative table. Each of its 64 entries holds a 20-bit virtual page number, a 6-bit address-space tag, a 20-bit physical frame number and four status bits: valid, dirty, referenced and write-permitted. An entry matches only when both the page number and the address-space tag agree. Several processes can therefore keep their translations in the table together, and a context switch needs no flush.

The three top address bits pick a segment. Two kernel windows are not translated. Their physical address is the virtual address with the top three bits cleared, and one of them is flagged uncached. Every other segment goes through the table.

Software owns refill. It watches for a miss, writes a whole entry through the write port in one cycle, and can clear every valid bit with one global invalidate. The lookup result is registered and appears one cycle after the request.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid and out_valid, out_hit, out_miss, out_prot and out_paddr are zero. A lookup in a translated segment then reports a miss.
- R2: A lookup requested with lk_en shows on the outputs after the next rising edge. out_valid is then 1 and exactly one of out_hit, out_miss and out_prot is 1. In a cycle after lk_en was 0, all outputs are 0.
- R3: Segments are decoded from lk_vaddr[31:29]. 100 and 101 bypass the table: the result is a hit with out_paddr = {3'b000, lk_vaddr[28:0]}, and out_uncached is 1 only for 101. The codes 000 to 011 and 110 to 111 are translated, and for them out_uncached is 0.
- R4: A translated lookup hits when a valid entry has a page number equal to lk_vaddr[31:12] and a tag equal to lk_asid. out_paddr is then {frame number, lk_vaddr[11:0]}, and out_dirty and out_ref give the entry's dirty and referenced bits.
- R5: An entry whose tag differs from lk_asid never matches. Two entries with the same page number and different tags each return their own frame number.
- R6: A lookup with lk_write = 1 that matches an entry whose write-permitted bit is 0 gives out_prot = 1 instead of a hit. A read of the same entry hits.
- R7: On a miss or a protection violation, out_paddr, out_dirty and out_ref are 0.
- R8: wr_en replaces every field of entry wr_idx at the rising edge. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new ones.
- R9: inv_all clears every valid bit at the rising edge. It takes precedence over a write in the same cycle, which is then ignored.
- R10: When several valid entries match, the entry with the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Address-space tag of the current context |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 6 | Index of the entry to write |
| wr_vpn | input | 20 | Virtual page number for the entry |
| wr_asid | input | 6 | Address-space tag for the entry |
| wr_pfn | input | 20 | Physical frame number for the entry |
| wr_valid | input | 1 | Valid bit for the entry |
| wr_dirty | input | 1 | Dirty bit for the entry |
| wr_ref | input | 1 | Referenced bit for the entry |
| wr_wok | input | 1 | Write-permitted bit for the entry |
| inv_all | input | 1 | Clear all valid bits |
| out_valid | output | 1 | A lookup result is present |
| out_hit | output | 1 | Translation succeeded |
| out_miss | output | 1 | No matching entry |
| out_prot | output | 1 | Store to an entry without write permission |
| out_uncached | output | 1 | Address is in the uncached bypass window |
| out_paddr | output | 32 | Physical address |
| out_dirty | output | 1 | Dirty bit of the hit entry |
| out_ref | output | 1 | Referenced bit of the hit entry |

## Verification
The assertions check on every cycle the rules that depend only on the previous request. These are:
- exactly one outcome per result, and quiet outputs when nothing was asked;
- the bypass address and uncached flag for the kernel windows;
- the page offset carried through on a translated hit;
- the absence of a protection fault on reads;
- zeroed address and status bits on a miss or a fault.

The contents of the table can only be judged against a history of writes, so the bench scenarios show the rest:
- matching on both page number and tag;
- lowest-index priority between duplicate entries;
- old-versus-new contents when a write and a lookup share a cycle;
- the precedence of invalidate over a write.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic              wr_ref,
  input  logic              wr_wok,
  input  logic              inv_all,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_miss,
  output logic              out_prot,
  output logic              out_uncached,
  output logic [PA_W-1:0]   out_paddr,
  output logic              out_dirty,
  output logic              out_ref
);

  logic [ENTRIES-1:0] e_valid, e_dirty, e_ref, e_wok;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       e_valid <= '0;
    else if (inv_all) e_valid <= '0;
    else if (wr_en)   e_valid[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) begin
      e_vpn[wr_idx]   <= wr_vpn;
      e_asid[wr_idx]  <= wr_asid;
      e_pfn[wr_idx]   <= wr_pfn;
      e_dirty[wr_idx] <= wr_dirty;
      e_ref[wr_idx]   <= wr_ref;
      e_wok[wr_idx]   <= wr_wok;
    end
  end

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1 -: VPN_W];
  wire [2:0]       seg    = lk_vaddr[VA_W-1 -: 3];
  wire             bypass = (seg[2:1] == 2'b10);

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = e_valid[g] && (e_vpn[g] == lk_vpn) && (e_asid[g] == lk_asid);
  end

  logic [IDX_W-1:0] sel;
  logic             found;
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  wire            denied  = found && lk_write && !e_wok[sel];
  wire            xl_ok   = !bypass && found && !denied;
  wire [PA_W-1:0] byp_pa  = {{(PA_W - VA_W + 3){1'b0}}, lk_vaddr[VA_W-4:0]};
  wire [PA_W-1:0] xl_pa   = {e_pfn[sel], lk_vaddr[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_hit <= 1'b0; out_miss <= 1'b0; out_prot <= 1'b0;
      out_uncached <= 1'b0; out_paddr <= '0; out_dirty <= 1'b0; out_ref <= 1'b0;
    end else begin
      out_valid    <= lk_en;
      out_hit      <= lk_en && (bypass || xl_ok);
      out_miss     <= lk_en && !bypass && !found;
      out_prot     <= lk_en && !bypass && denied;
      out_uncached <= lk_en && (seg == 3'b101);
      out_paddr    <= !lk_en ? '0 : bypass ? byp_pa : xl_ok ? xl_pa : '0;
      out_dirty    <= lk_en && xl_ok && e_dirty[sel];
      out_ref      <= lk_en && xl_ok && e_ref[sel];
    end
  end

endmodule

module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
)(
  input logic            clk,
  input logic            rst_n,
  input logic            lk_en,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_write,
  input logic            out_valid,
  input logic            out_hit,
  input logic            out_miss,
  input logic            out_prot,
  input logic            out_uncached,
  input logic [PA_W-1:0] out_paddr,
  input logic            out_dirty,
  input logic            out_ref
);
  wire in_bypass = (lk_vaddr[VA_W-1 -: 2] == 2'b10);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_hit, out_miss, out_prot}) == 1); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !out_valid && !out_hit && !out_miss && !out_prot && out_paddr == '0); // R2
  AST_BYPASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && in_bypass) |=> out_hit && out_paddr == PA_W'($past(lk_vaddr[VA_W-4:0]))); // R3
  AST_UNCACHED_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> out_uncached == ($past(lk_vaddr[VA_W-1 -: 3]) == 3'b101)); // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !in_bypass) |=> !out_hit || out_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])); // R4
  AST_READ_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !lk_write) |=> !out_prot); // R6
  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> out_paddr == '0 && !out_dirty && !out_ref); // R7
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
  .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss), .out_prot(out_prot),
  .out_uncached(out_uncached), .out_paddr(out_paddr), .out_dirty(out_dirty), .out_ref(out_ref)
);

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;
  logic clk = 0, rst_n = 0;
  logic lk_en = 0, lk_write = 0, wr_en = 0, wr_valid = 0, wr_dirty = 0, wr_ref = 0, wr_wok = 0, inv_all = 0;
  logic [31:0] lk_vaddr = 0;
  logic [5:0]  lk_asid = 0, wr_idx = 0, wr_asid = 0;
  logic [19:0] wr_vpn = 0, wr_pfn = 0;
  logic out_valid, out_hit, out_miss, out_prot, out_uncached, out_dirty, out_ref;
  logic [31:0] out_paddr;

  always #2 clk = ~clk;

  tlb_xlate u_dut (.*);

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit run = 0;

  bit m_valid[64], m_dirty[64], m_ref[64], m_wok[64];
  logic [19:0] m_vpn[64], m_pfn[64];
  logic [5:0]  m_asid[64];
  logic e_v, e_hit, e_miss, e_prot, e_unc, e_d, e_r;
  logic [31:0] e_pa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_valid[i] = 0;
      {e_v, e_hit, e_miss, e_prot, e_unc, e_d, e_r} = '0;
      e_pa = 0;
    end else begin
      {e_hit, e_miss, e_prot, e_unc, e_d, e_r} = '0;
      e_v = lk_en;
      e_pa = 0;
      if (lk_en) begin
        if (lk_vaddr[31:29] == 3'b100 || lk_vaddr[31:29] == 3'b101) begin
          e_hit = 1;
          e_pa = {3'b000, lk_vaddr[28:0]};
          e_unc = (lk_vaddr[31:29] == 3'b101);
        end else begin
          int idx;
          idx = -1;
          for (int i = 0; i < 64; i++)
            if (idx < 0 && m_valid[i] && m_vpn[i] == lk_vaddr[31:12] && m_asid[i] == lk_asid) idx = i;
          if (idx < 0) e_miss = 1;
          else if (lk_write && !m_wok[idx]) e_prot = 1;
          else begin
            e_hit = 1;
            e_pa = {m_pfn[idx], lk_vaddr[11:0]};
            e_d = m_dirty[idx];
            e_r = m_ref[idx];
          end
        end
      end
      if (inv_all) begin
        for (int i = 0; i < 64; i++) m_valid[i] = 0;
      end else if (wr_en) begin
        m_valid[wr_idx] = wr_valid; m_vpn[wr_idx] = wr_vpn; m_asid[wr_idx] = wr_asid;
        m_pfn[wr_idx] = wr_pfn; m_dirty[wr_idx] = wr_dirty; m_ref[wr_idx] = wr_ref; m_wok[wr_idx] = wr_wok;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && run) begin
      n_chk++;
      if ({out_valid, out_hit, out_miss, out_prot, out_uncached, out_dirty, out_ref} !==
          {e_v, e_hit, e_miss, e_prot, e_unc, e_d, e_r} || out_paddr !== e_pa) begin
        n_err++;
        $display("FAIL %s model: actual v%b h%b m%b p%b u%b d%b r%b pa=%h expected v%b h%b m%b p%b u%b d%b r%b pa=%h",
          cur_req, out_valid, out_hit, out_miss, out_prot, out_uncached, out_dirty, out_ref, out_paddr,
          e_v, e_hit, e_miss, e_prot, e_unc, e_d, e_r, e_pa);
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] va, logic [5:0] asid, logic w);
    @(negedge clk);
    lk_en = 1; lk_vaddr = va; lk_asid = asid; lk_write = w;
    @(negedge clk);
    lk_en = 0; lk_write = 0;
  endtask

  task automatic wr(logic [5:0] idx, logic [19:0] vpn, logic [5:0] asid, logic [19:0] pfn,
                    logic v, logic d, logic r, logic w);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
    wr_valid = v; wr_dirty = d; wr_ref = r; wr_wok = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 reset outputs", {out_valid, out_hit, out_miss, out_prot, out_paddr}, 0);
    look(32'h0040_0000, 6'd0, 0);
    chk("R1 miss after reset", {out_valid, out_miss}, 2'b11);

    cur_req = "R4";
    wr(6'd5, 20'h00012, 6'd3, 20'hABCDE, 1, 1, 0, 1);
    look(32'h0001_2345, 6'd3, 0);
    chk("R4 hit address", {out_hit, out_paddr}, {1'b1, 32'hABCD_E345});
    chk("R4 status bits", {out_dirty, out_ref, out_uncached}, 3'b100);

    cur_req = "R5";
    look(32'h0001_2345, 6'd4, 0);
    chk("R5 tag mismatch miss", {out_miss, out_hit}, 2'b10);
    wr(6'd9, 20'h00012, 6'd4, 20'h11111, 1, 0, 1, 0);
    look(32'h0001_2345, 6'd4, 0);
    chk("R5 second tag", out_paddr, 32'h1111_1345);
    look(32'h0001_2345, 6'd3, 0);
    chk("R5 first tag kept", out_paddr, 32'hABCD_E345);

    cur_req = "R6";
    look(32'h0001_2345, 6'd4, 1);
    chk("R6 store denied", {out_prot, out_hit, out_miss}, 3'b100);
    cur_req = "R7";
    chk("R7 denied zero addr", {out_paddr, out_dirty, out_ref}, 0);
    look(32'h0001_2FFF, 6'd3, 1);
    chk("R6 store permitted", {out_hit, out_paddr}, {1'b1, 32'hABCD_EFFF});

    cur_req = "R3";
    look(32'h8123_4567, 6'd9, 0);
    chk("R3 cached bypass", {out_hit, out_uncached, out_paddr}, {2'b10, 32'h0123_4567});
    look(32'hA123_4567, 6'd9, 1);
    chk("R3 uncached bypass", {out_hit, out_uncached, out_paddr}, {2'b11, 32'h0123_4567});
    look(32'hC000_1000, 6'd0, 0);
    chk("R3 kernel mapped miss", out_miss, 1'b1);
    wr(6'd2, 20'hC0001, 6'd0, 20'h00077, 1, 0, 1, 1);
    look(32'hC000_1ABC, 6'd0, 0);
    chk("R3 kernel mapped hit", {out_hit, out_uncached, out_ref, out_paddr}, {3'b101, 32'h0007_7ABC});

    cur_req = "R10";
    wr(6'd20, 20'h00012, 6'd3, 20'h22222, 1, 0, 0, 1);
    look(32'h0001_2345, 6'd3, 0);
    chk("R10 lowest index wins", out_paddr, 32'hABCD_E345);
    wr(6'd5, 20'h00012, 6'd3, 20'hABCDE, 0, 0, 0, 1);
    look(32'h0001_2345, 6'd3, 0);
    chk("R10 next index after clear", out_paddr, 32'h2222_2345);

    cur_req = "R8";
    @(negedge clk);
    wr_en = 1; wr_idx = 6'd20; wr_vpn = 20'h00012; wr_asid = 6'd3; wr_pfn = 20'h33333;
    wr_valid = 1; wr_dirty = 1; wr_ref = 1; wr_wok = 1;
    lk_en = 1; lk_vaddr = 32'h0001_2345; lk_asid = 6'd3;
    @(negedge clk);
    wr_en = 0; lk_en = 0;
    chk("R8 same-cycle old value", {out_dirty, out_paddr}, {1'b0, 32'h2222_2345});
    look(32'h0001_2345, 6'd3, 0);
    chk("R8 new value next cycle", {out_dirty, out_ref, out_paddr}, {2'b11, 32'h3333_3345});

    cur_req = "R9";
    @(negedge clk);
    inv_all = 1; wr_en = 1; wr_idx = 6'd30; wr_vpn = 20'h00055; wr_asid = 6'd1; wr_valid = 1; wr_pfn = 20'h44444;
    @(negedge clk);
    inv_all = 0; wr_en = 0;
    look(32'h0001_2345, 6'd3, 0);
    chk("R9 invalidated entry misses", out_miss, 1'b1);
    look(32'h0005_5000, 6'd1, 0);
    chk("R9 write under invalidate ignored", out_miss, 1'b1);

    cur_req = "R2";
    @(negedge clk);
    chk("R2 idle outputs", {out_valid, out_hit, out_miss, out_prot}, 4'b0000);
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r, q;
      r = $urandom; q = $urandom;
      @(negedge clk);
      wr_en = (q[3:0] < 4);
      inv_all = (q[9:4] == 0);
      wr_idx = q[15:10]; wr_vpn = {q[31:29], 14'b0, q[18:16]}; wr_asid = {4'b0, q[20:19]};
      wr_pfn = {q[27:21], 13'h0F0F}; wr_valid = q[28] | q[0]; wr_dirty = q[1]; wr_ref = q[2]; wr_wok = q[8];
      lk_en = r[3]; lk_write = r[4];
      lk_vaddr = {r[31:29], 14'b0, r[2:0], r[16:5]}; lk_asid = {4'b0, r[18:17]};
    end
    @(negedge clk);
    wr_en = 0; inv_all = 0; lk_en = 0;
    @(negedge clk);
    finish_run();
  end
endmodule